// File: doc/BRIEF.md
# Mode-Selected CPU/PCI Clock Divider

This block turns one internal base clock into a processor clock, a bus clock at a third or a half of the processor rate, and a reference-clock passthrough. A two-bit select picks one of four modes: every output disabled, running at the lower processor rate, a test mode driven by a slow test clock, or running at the higher processor rate. In both running modes the processor clock is the base clock divided by two. The bus clock is the processor clock divided by two at the lower rate and by three at the higher rate. Each bus rising edge is placed one base cycle after a processor rising edge, so the processor clock always leads.

Every output is a registered level with its own output-enable flag, so pads or a wrapper outside the block can tri-state them. A change of the select is passed through two flops and takes effect only when the internal phase counter wraps. That point is where the processor and bus clocks are both about to rise, so a rate switch in the middle of a run creates no short pulse.

Top module: `clkgen_div`

## Requirements
- R1: After reset every enable flag is low, every clock output is low and the block is in the disabled mode.
- R2: Select code 00 (bit 1 = rate, bit 0 = run) is the disabled mode: all four enable flags are low and all clock outputs are held low whatever `ref_in` and `tclk_in` do.
- R3: In codes 01 and 11 the processor clock outputs toggle on every base cycle: a period of 2 base cycles at 50% duty.
- R4: In code 01 the bus clock has a period of 4 base cycles, 2 high and 2 low, which is two processor periods.
- R5: In code 11 the bus clock has a period of 6 base cycles, 3 high and 3 low, which is three processor periods.
- R6: In the running modes each bus rising edge appears one base cycle after a processor rising edge: in the sample where the bus clock first reads high, the processor clock reads low, and it read high in the sample before.
- R7: In the running modes `ref_clk` equals the value `ref_in` had one base cycle earlier.
- R8: In code 10 the processor clocks have a period of two `tclk_in` periods, the bus clocks six `tclk_in` periods, and `ref_clk` has the period and duty of `tclk_in`. All enable flags are high.
- R9: A select change reaches the mode register only after two synchronizing flops and only at a phase-counter wrap. A switch between the two running modes leaves every bus high or low run at 2 or 3 base cycles, and R6 still holds.
- R10: All bus clock outputs and the free-running bus clock carry the same waveform, and the enable flags are high in codes 01, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base clock, twice the processor rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode select: bit 1 rate, bit 0 run |
| ref_in | input | 1 | Crystal-rate reference level to pass through |
| tclk_in | input | 1 | Test clock, oversampled by the base clock |
| cpu_clk | output | NCPU | Processor clock outputs |
| cpu_oe | output | 1 | Enable flag for processor outputs |
| pci_clk | output | NPCI | Bus clock outputs |
| pci_oe | output | 1 | Enable flag for bus outputs |
| pcif_clk | output | 1 | Free-running bus clock output |
| pcif_oe | output | 1 | Enable flag for free-running bus output |
| ref_clk | output | 1 | Reference clock output |
| ref_oe | output | 1 | Enable flag for reference output |

## Verification
Each running mode is held steady so that every bus high run, every bus low run and every processor transition can be measured. Those measurements separate a ratio of 2 from a ratio of 3 and an aligned bus edge from a misplaced one. A rate switch made mid-run looks for runt pulses and for a lost alignment at the commit point. The test mode uses a slow square wave on `tclk_in` and measures the intervals between rising edges, which tells the divide-by-2, divide-by-6 and passthrough paths apart. The disabled mode and the reference passthrough are driven with a changing `ref_in` pattern, so that a stuck or leaking output shows up.

// File: rtl/clkgen_div.sv
module clkgen_div #(
  parameter int NCPU = 2,
  parameter int NPCI = 5
) (
  input  logic            clk_base,
  input  logic            rst_n,
  input  logic [1:0]      mode_sel,
  input  logic            ref_in,
  input  logic            tclk_in,
  output logic [NCPU-1:0] cpu_clk,
  output logic            cpu_oe,
  output logic [NPCI-1:0] pci_clk,
  output logic            pci_oe,
  output logic            pcif_clk,
  output logic            pcif_oe,
  output logic            ref_clk,
  output logic            ref_oe
);
  typedef enum logic [1:0] {M_OFF = 2'b00, M_LO = 2'b01, M_TST = 2'b10, M_HI = 2'b11} mode_t;

  localparam int PHW = 3;
  localparam logic [PHW-1:0] LAST_LO = PHW'(3);
  localparam logic [PHW-1:0] LAST_HI = PHW'(5);
  localparam logic [PHW-1:0] HALF_LO = PHW'(2);
  localparam logic [PHW-1:0] HALF_HI = PHW'(3);

  logic [1:0]     sel_s1, sel_s2;
  mode_t          cur;
  logic [PHW-1:0] ph, ph_last, half;
  logic           run, tst, on;
  logic           cpu_a, pci_a;
  logic           t1, t2, t3, trise;
  logic [1:0]     tcnt;
  logic           tcpu, tpci;
  logic           cpu_r, pci_r, ref_r, oe_r;

  assign run     = cur[0];
  assign tst     = (cur == M_TST);
  assign on      = (cur != M_OFF);
  assign ph_last = (cur == M_HI) ? LAST_HI : LAST_LO;
  assign half    = (cur == M_HI) ? HALF_HI : HALF_LO;
  assign cpu_a   = ~ph[0];
  assign pci_a   = (ph != '0) && (ph <= half);
  assign trise   = t2 & ~t3;

  always_ff @(posedge clk_base or negedge rst_n) begin
    if (!rst_n) begin
      sel_s1 <= '0;
      sel_s2 <= '0;
      cur    <= M_OFF;
      ph     <= '0;
    end else begin
      sel_s1 <= mode_sel;
      sel_s2 <= sel_s1;
      if (ph == ph_last) begin
        ph  <= '0;
        cur <= mode_t'(sel_s2);
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_base or negedge rst_n) begin
    if (!rst_n) begin
      t1 <= 1'b0;
      t2 <= 1'b0;
      t3 <= 1'b0;
    end else begin
      t1 <= tclk_in;
      t2 <= t1;
      t3 <= t2;
    end
  end

  always_ff @(posedge clk_base or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      tcpu <= 1'b0;
      tpci <= 1'b0;
    end else if (!tst) begin
      tcnt <= '0;
      tcpu <= 1'b0;
      tpci <= 1'b0;
    end else if (trise) begin
      tcpu <= ~tcpu;
      if (tcnt == 2'd2) begin
        tcnt <= '0;
        tpci <= ~tpci;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_base or negedge rst_n) begin
    if (!rst_n) begin
      cpu_r <= 1'b0;
      pci_r <= 1'b0;
      ref_r <= 1'b0;
      oe_r  <= 1'b0;
    end else begin
      oe_r <= on;
      if (run) begin
        cpu_r <= cpu_a;
        pci_r <= pci_a;
        ref_r <= ref_in;
      end else if (tst) begin
        cpu_r <= tcpu;
        pci_r <= tpci;
        ref_r <= t2;
      end else begin
        cpu_r <= 1'b0;
        pci_r <= 1'b0;
        ref_r <= 1'b0;
      end
    end
  end

  assign cpu_clk  = {NCPU{cpu_r}};
  assign pci_clk  = {NPCI{pci_r}};
  assign pcif_clk = pci_r;
  assign ref_clk  = ref_r;
  assign cpu_oe   = oe_r;
  assign pci_oe   = oe_r;
  assign pcif_oe  = oe_r;
  assign ref_oe   = oe_r;
endmodule

// File: rtl/clkgen_div_chk.sv
module clkgen_div_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic [2:0] ph,
  input logic       cpu,
  input logic       pci,
  input logic       refc,
  input logic       ref_in,
  input logic       oe
);
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!cpu && !pci && !refc));

  p_cpu_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && $past(mode[0])) |=> (cpu != $past(cpu)));

  p_phase_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= 3'd5);

  p_pci_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pci) && $past(mode[0])) |-> ($past(cpu) && !cpu));

  p_ref_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode[0]) |-> (refc == $past(ref_in)));

  p_commit_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> (ph == 3'd0));
endmodule

bind clkgen_div clkgen_div_chk u_chk (
  .clk(clk_base), .rst_n(rst_n), .mode(cur), .ph(ph), .cpu(cpu_clk[0]),
  .pci(pci_clk[0]), .refc(ref_clk), .ref_in(ref_in), .oe(cpu_oe)
);

// File: tb/clkgen_div_bench.sv
module clkgen_div_bench;
  localparam int NCPU = 2;
  localparam int NPCI = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode_sel = 2'b00;
  logic            ref_in = 1'b0;
  logic            tclk_in = 1'b0;
  logic [NCPU-1:0] cpu_clk;
  logic [NPCI-1:0] pci_clk;
  logic            cpu_oe, pci_oe, pcif_clk, pcif_oe, ref_clk, ref_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clkgen_div #(.NCPU(NCPU), .NPCI(NPCI)) u_clkgen_div (
    .clk_base(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_in(ref_in), .tclk_in(tclk_in),
    .cpu_clk(cpu_clk), .cpu_oe(cpu_oe), .pci_clk(pci_clk), .pci_oe(pci_oe),
    .pcif_clk(pcif_clk), .pcif_oe(pcif_oe), .ref_clk(ref_clk), .ref_oe(ref_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit uniform();
    return (pci_clk == {NPCI{pcif_clk}}) && (cpu_clk == {NCPU{cpu_clk[0]}});
  endfunction

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // half == 0 accepts runs of 2 or 3 (mode switch window)
  task automatic measure_run(input int half, input int n, input string tag);
    int run = 0, cpu_bad = 0, run_bad = 0, al_bad = 0, uni_bad = 0, bad_len = 0;
    bit first = 1'b1;
    logic pc = 1'b0, pp = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!uniform() || !cpu_oe || !pci_oe || !pcif_oe || !ref_oe) uni_bad++;
      if (i > 0) begin
        if (cpu_clk[0] == pc) cpu_bad++;
        if (pci_clk[0] != pp) begin
          if (!first) begin
            if ((half == 0 && run != 2 && run != 3) || (half != 0 && run != half)) begin
              run_bad++;
              bad_len = run;
            end
          end
          first = 1'b0;
          run = 1;
          if (pci_clk[0] && !(pc && !cpu_clk[0])) al_bad++;
        end else run++;
      end else run = 1;
      pc = cpu_clk[0];
      pp = pci_clk[0];
    end
    chk(cpu_bad == 0, {tag, " R3 cpu toggles every base cycle"}, cpu_bad, 0);
    chk(run_bad == 0, {tag, (half == 2) ? " R4 pci run length" : (half == 3) ? " R5 pci run length" : " R9 no runt pci run"},
        bad_len, half);
    chk(al_bad == 0, {tag, " R6 pci rise one cycle after cpu rise"}, al_bad, 0);
    chk(uni_bad == 0, {tag, " R10 outputs uniform and enabled"}, uni_bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!cpu_oe && !pci_oe && !pcif_oe && !ref_oe, "R1 enables low in reset", cpu_oe, 0);
    chk(cpu_clk == '0 && pci_clk == '0 && !pcif_clk && !ref_clk, "R1 clocks low in reset", int'(cpu_clk), 0);
    rst_n = 1'b1;
    wait_cycles(3);
    chk(!cpu_oe && cpu_clk == '0 && pci_clk == '0, "R1 disabled mode after reset", cpu_oe, 0);
  endtask

  task automatic t_off();
    int bad = 0;
    mode_sel = 2'b00;
    wait_cycles(16);
    for (int i = 0; i < 40; i++) begin
      ref_in = (i % 3) == 0;
      tclk_in = (i % 4) < 2;
      @(negedge clk);
      if (cpu_oe || pci_oe || pcif_oe || ref_oe || cpu_clk != '0 || pci_clk != '0 || pcif_clk || ref_clk) bad++;
    end
    tclk_in = 1'b0;
    chk(bad == 0, "R2 disabled mode quiet", bad, 0);
  endtask

  task automatic t_lo();
    mode_sel = 2'b01;
    wait_cycles(16);
    measure_run(2, 60, "lo");
  endtask

  task automatic t_hi();
    mode_sel = 2'b11;
    wait_cycles(16);
    measure_run(3, 72, "hi");
  endtask

  task automatic t_ref();
    int bad = 0;
    logic last = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (i > 0 && ref_clk != last) bad++;
      last = ((i * 7) % 5) < 2;
      ref_in = last;
    end
    @(negedge clk);
    if (ref_clk != last) bad++;
    chk(bad == 0, "R7 reference passthrough", bad, 0);
  endtask

  task automatic t_switch();
    mode_sel = 2'b01;
    wait_cycles(16);
    mode_sel = 2'b11;
    measure_run(0, 40, "lo->hi");
    measure_run(3, 36, "hi settled");
    mode_sel = 2'b01;
    measure_run(0, 40, "hi->lo");
    measure_run(2, 36, "lo settled");
  endtask

  task automatic t_test();
    int lc = -1, lp = -1, lr = -1, lcf = -1;
    int cper = 0, pper = 0, rper = 0, chigh = 0, rhigh = 0, lrf = -1;
    int cbad = 0, pbad = 0, rbad = 0, hbad = 0, oebad = 0;
    logic pc = 1'b0, pp = 1'b0, pr = 1'b0;
    mode_sel = 2'b10;
    for (int i = 0; i < 420; i++) begin
      tclk_in = (i % 8) < 4;
      @(negedge clk);
      if (i >= 60) begin
        if (!cpu_oe || !pci_oe || !pcif_oe || !ref_oe || !uniform()) oebad++;
        if (cpu_clk[0] && !pc) begin
          if (lc >= 0 && i - lc != 16) cbad++;
          lc = i;
        end
        if (!cpu_clk[0] && pc) begin
          if (lc >= 0 && i - lc != 8) hbad++;
          lcf = i;
        end
        if (pci_clk[0] && !pp) begin
          if (lp >= 0 && i - lp != 48) pbad++;
          lp = i;
          pper++;
        end
        if (ref_clk && !pr) begin
          if (lr >= 0 && i - lr != 8) rbad++;
          lr = i;
          rper++;
        end
        if (!ref_clk && pr) begin
          if (lr >= 0 && i - lr != 4) hbad++;
          lrf = i;
        end
      end
      pc = cpu_clk[0];
      pp = pci_clk[0];
      pr = ref_clk;
    end
    tclk_in = 1'b0;
    chk(cbad == 0 && lc >= 0 && lcf >= 0, "R8 test cpu period two tclk", cbad, 0);
    chk(pbad == 0 && pper >= 3, "R8 test pci period six tclk", pper, 6);
    chk(rbad == 0 && rper >= 10, "R8 test ref follows tclk", rper, 45);
    chk(hbad == 0, "R8 test duty", hbad, 0);
    chk(oebad == 0, "R8 test enables high", oebad, 0);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_off();
    t_lo();
    t_ref();
    t_hi();
    t_ref();
    t_switch();
    t_test();
    t_hi();
    t_off();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule